// File: doc/BRIEF.md
# Output Rounding, Clamping and Format Stage

This block is the last stage of a half-band filter datapath. It takes the 20-bit signed accumulator result and reduces it to a 16-bit output word. A 3-bit code sets the position of the word's effective least significant bit, anywhere from bit 0 to bit 7. Half of that LSB is added to the result, and every bit below it is cleared.

If the rounded value no longer fits in 16 signed bits, it is clamped to full scale. The word can then be presented in two's complement or in inverted offset binary. It is captured in an output register when a load strobe is high. An active-low output enable drives the register contents onto the output pins, or releases them to high impedance, without waiting for a clock.

The accumulator carries four fraction bits below output bit 0 in the normal and decimating modes. When the interpolating path is selected, the input weighting moves down by one bit, so three fraction bits remain.

Top module: `rndfmt_stage`

## Requirements
- R1: With rndSel = k (0 to 7), output bits k-1 down to 0 of a loaded word are zero unless the value was clamped, and bit k is the effective LSB.
- R2: Before truncation, a one is added at the bit one below the effective LSB. Results exactly halfway round toward positive infinity.
- R3: With interpMode low, output bit 0 at k=0 carries input bit 4 (input bits 3..0 are fraction). With interpMode high, output bit 0 carries input bit 3.
- R4: The overflow check is made after the rounding addition. A value above 32767 loads 0x7FFF and a value below -32768 loads 0x8000, as two's-complement words.
- R5: With twosComp high, the loaded word is two's complement. With twosComp low, bit 15 is kept and bits 14..0 are inverted, and this also applies to clamped words.
- R6: The register loads the formatted word on a rising clock edge where loadEn is high, and holds its value while loadEn is low.
- R7: With oeN low, dOut shows the register. With oeN high, dOut is high impedance. Both responses are combinational in oeN.
- R8: An active-low asynchronous rstN clears the register to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| din | input | 20 | Signed filter result |
| rndSel | input | 3 | Effective LSB position of the output word |
| twosComp | input | 1 | 1: two's complement, 0: inverted offset binary |
| interpMode | input | 1 | Selects the interpolating input weighting |
| loadEn | input | 1 | Output register load strobe |
| oeN | input | 1 | Output enable, active low, asynchronous |
| dOut | output | 16 | Registered output word or high impedance |

## Verification
The hardest case to reach is an input just below the positive limit that overflows only because of the rounding increment. Whether this happens depends on the rounding code, because the increment lands at a different bit for each code. Random 20-bit inputs almost never land in that narrow band. The directed stimulus therefore builds, for every code and both input weightings, the value one step below the clamp threshold and the value that crosses it, in both output formats. Random words with random codes fill in the ordinary cases.

// File: rtl/rndfmt_pkg.sv
package rndfmt_pkg;
  typedef struct packed {
    logic       load;
    logic       twos;
    logic [2:0] lsbPos;
    logic [4:0] dropBits;
  } fmtCtrl_t;
endpackage

// File: rtl/rndfmt_ctrl.sv
module rndfmt_ctrl
  import rndfmt_pkg::*;
#(
  parameter int IN_W   = 20,
  parameter int FRAC_W = 4,
  localparam int SUM_W = IN_W + 1
) (
  input  logic             loadEn,
  input  logic             twosComp,
  input  logic             interpMode,
  input  logic [2:0]       rndSel,
  output fmtCtrl_t         ctrl,
  output logic [SUM_W-1:0] roundAdd
);
  logic [4:0] fracBits;

  always_comb begin
    fracBits      = 5'(FRAC_W) - {4'd0, interpMode};
    ctrl.load     = loadEn;
    ctrl.twos     = twosComp;
    ctrl.lsbPos   = rndSel;
    ctrl.dropBits = fracBits + {2'd0, rndSel};
    roundAdd      = SUM_W'(1) << (ctrl.dropBits - 5'd1);
  end
endmodule

// File: rtl/rndfmt_dp.sv
module rndfmt_dp
  import rndfmt_pkg::*;
#(
  parameter int IN_W   = 20,
  parameter int OUT_W  = 16,
  localparam int SUM_W = IN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  din,
  input  fmtCtrl_t         ctrl,
  input  logic [SUM_W-1:0] roundAdd,
  output logic [OUT_W-1:0] outReg
);
  localparam logic signed [SUM_W-1:0] MaxVal = SUM_W'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MinVal = -SUM_W'(1 <<< (OUT_W - 1));

  logic signed [SUM_W-1:0] sumExt;
  logic signed [SUM_W-1:0] kept;
  logic                    ovfHi;
  logic                    ovfLo;
  logic [OUT_W-1:0]        satWord;
  logic [OUT_W-1:0]        fmtWord;

  assign sumExt = $signed({din[IN_W-1], din}) + $signed(roundAdd);
  assign kept   = (sumExt >>> ctrl.dropBits) <<< ctrl.lsbPos;
  assign ovfHi  = kept > MaxVal;
  assign ovfLo  = kept < MinVal;

  always_comb begin
    if (ovfHi)      satWord = {1'b0, {(OUT_W-1){1'b1}}};
    else if (ovfLo) satWord = {1'b1, {(OUT_W-1){1'b0}}};
    else            satWord = kept[OUT_W-1:0];
  end

  assign fmtWord[OUT_W-1] = satWord[OUT_W-1];
  for (genvar b = 0; b < OUT_W - 1; b++) begin : g_fmt
    assign fmtWord[b] = ctrl.twos ? satWord[b] : ~satWord[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outReg <= '0;
    else if (ctrl.load) outReg <= fmtWord;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(outReg));

  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.twos && !ovfHi && !ovfLo) |=>
      ((outReg & ((OUT_W'(1) << $past(ctrl.lsbPos)) - OUT_W'(1))) == '0));

  p_clamp_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.twos && $signed(din) > 0 && ovfHi) |=>
      (outReg == {1'b0, {(OUT_W-1){1'b1}}}));

  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.twos && ovfLo) |=> (outReg == {OUT_W{1'b1}}));

  p_msb_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (outReg[OUT_W-1] == $past(satWord[OUT_W-1])));
endmodule

// File: rtl/rndfmt_stage.sv
module rndfmt_stage
  import rndfmt_pkg::*;
#(
  parameter int IN_W   = 20,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  din,
  input  logic [2:0]       rndSel,
  input  logic             twosComp,
  input  logic             interpMode,
  input  logic             loadEn,
  input  logic             oeN,
  output logic [OUT_W-1:0] dOut
);
  localparam int SUM_W = IN_W + 1;

  fmtCtrl_t         ctrl;
  logic [SUM_W-1:0] roundAdd;
  logic [OUT_W-1:0] outReg;

  rndfmt_ctrl #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_ctrl (
    .loadEn(loadEn), .twosComp(twosComp), .interpMode(interpMode),
    .rndSel(rndSel), .ctrl(ctrl), .roundAdd(roundAdd)
  );

  rndfmt_dp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .din(din), .ctrl(ctrl),
    .roundAdd(roundAdd), .outReg(outReg)
  );

  assign dOut = oeN ? {OUT_W{1'bz}} : outReg;

  p_reset_r8: assert property (@(posedge clk) $fell(rstN) |-> (outReg == '0));
endmodule

// File: tb/rndfmt_stage_bench.sv
module rndfmt_stage_bench;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] din = '0;
  logic [2:0]  rndSel = '0;
  logic        twosComp = 1'b1;
  logic        interpMode = 1'b0;
  logic        loadEn = 1'b0;
  logic        oeN = 1'b0;
  logic [15:0] dOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] lastExp = '0;

  always #(ClkPeriod/2) clk = ~clk;

  rndfmt_stage u_rndfmt_stage (
    .clk(clk), .rstN(rstN), .din(din), .rndSel(rndSel), .twosComp(twosComp),
    .interpMode(interpMode), .loadEn(loadEn), .oeN(oeN), .dOut(dOut)
  );

  function automatic logic [15:0] model(logic [19:0] d, int k, bit tw, bit ip);
    longint v, frac, w;
    logic [15:0] s;
    frac = ip ? 3 : 4;
    v = longint'($signed(d)) + (longint'(1) <<< (frac + k - 1));
    w = (v >>> (frac + k)) <<< k;
    if (w > 32767) s = 16'h7FFF;
    else if (w < -32768) s = 16'h8000;
    else s = w[15:0];
    return tw ? s : {s[15], ~s[14:0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic loadOne(string req, logic [19:0] d, int k, bit tw, bit ip);
    @(negedge clk);
    din = d; rndSel = 3'(k); twosComp = tw; interpMode = ip; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    lastExp = model(d, k, tw, ip);
    check(req, dOut, lastExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R8 reset", dOut, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 after reset", dOut, 16'h0000);

    // R3: weighting of bit 0 in each mode
    loadOne("R3 normal weight", 20'h00010, 0, 1, 0);
    check("R3 normal value", dOut, 16'h0001);
    loadOne("R3 interp weight", 20'h00008, 0, 1, 1);
    check("R3 interp value", dOut, 16'h0001);

    // R2: halfway rounds up, just below rounds down
    loadOne("R2 half up", 20'h00008, 0, 1, 0);
    check("R2 half up value", dOut, 16'h0001);
    loadOne("R2 below half", 20'h00007, 0, 1, 0);
    loadOne("R2 neg half", 20'hFFFF8, 0, 1, 0);
    check("R2 neg half value", dOut, 16'h0000);

    // R1, R4, R5: every code, both weightings, both formats, around the limits
    for (int k = 0; k < 8; k++) begin
      for (int ip = 0; ip < 2; ip++) begin
        for (int tw = 0; tw < 2; tw++) begin
          int fr;
          longint thr;
          fr = 4 - ip;
          thr = (longint'(32768) <<< fr) - (longint'(1) <<< (fr + k - 1));
          loadOne("R4 cross high", 20'(thr), k, tw[0], ip[0]);
          loadOne("R1 just below high", 20'(thr - 1), k, tw[0], ip[0]);
          loadOne("R4 full negative", 20'h80000, k, tw[0], ip[0]);
          loadOne("R4 full positive", 20'h7FFFF, k, tw[0], ip[0]);
          loadOne("R5 small negative", 20'hFFF35, k, tw[0], ip[0]);
        end
      end
    end

    // R4 R5 directed: clamped word in inverted offset binary
    loadOne("R5 clamp hi inverted", 20'h7FFFF, 0, 0, 0);
    check("R5 clamp hi inverted value", dOut, 16'h0000);
    loadOne("R5 clamp lo inverted", 20'h80000, 0, 0, 0);
    check("R5 clamp lo inverted value", dOut, 16'hFFFF);

    // random mix, R1 R2 R5
    for (int i = 0; i < 400; i++) begin
      loadOne("R1 random", 20'($urandom), int'($urandom_range(0, 7)),
              bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    // R6: hold while loadEn low
    loadOne("R6 load", 20'h12345, 2, 1, 0);
    @(negedge clk);
    din = 20'h54321; rndSel = 3'd0; loadEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 hold", dOut, lastExp);

    // R7: asynchronous output enable
    loadOne("R7 preload", 20'h7FFFF, 0, 1, 0);
    #2 oeN = 1'b1;
    #1 checks++;
    if (dOut === 16'h7FFF) begin
      errors++;
      $display("FAIL R7 disable actual=%h expected=zz", dOut);
    end
    #1 oeN = 1'b0;
    #1 check("R7 enable", dOut, 16'h7FFF);

    finishRun();
  end
endmodule